// File: doc/BRIEF.md
# Banked Interrupt Controller with Per-Source Trigger Selection

This block gathers interrupt requests from up to `NUM_BANKS` groups of 32 sources and presents one request line per group to the processor. Each source is independently configured as active-high level, active-low level, rising-edge or falling-edge through two configuration bits, polarity and trigger-mode. Edge events and software requests are latched until acknowledged. Level conditions are shown live.

Software reaches every group through a single-cycle 32-bit register port. Each group occupies a 24-byte window, so group `b` starts at byte address `b*24`. The window holds six word registers. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`.

For each group the block also reports the index of the lowest-numbered source that is both pending and enabled. A dispatcher can use this index directly, without a software bit scan.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset the enable and status registers of every group read 0 and the polarity registers read 0xFFFFFFFF. The trigger-mode register reads 0x0000E000 in group 0 (sources 13, 14 and 15 edge-triggered) and 0 in every other group.
- R2: Group `b` decodes byte addresses `b*24` to `b*24+23`, with word offsets 0x0 status, 0x4 enable, 0x8 set, 0xC clear, 0x10 polarity and 0x14 trigger-mode. The set and clear offsets read 0. Addresses at or beyond `NUM_BANKS*24` read 0.
- R3: A source with trigger-mode 0 is level-sensitive. Its status bit equals the input when polarity is 1 and the inverted input when polarity is 0, two clocks after the input changes.
- R4: A source with trigger-mode 1 and polarity 1 latches a 0-to-1 input transition into its status bit. The bit stays set after the input returns low.
- R5: A source with trigger-mode 1 and polarity 0 latches a 1-to-0 transition and ignores a 0-to-1 transition.
- R6: Writing 1 to a bit at the clear offset drops that source's latched status, and writing 0 leaves it unchanged. A level source whose input is still active stays pending after a clear.
- R7: Writing 1 to a bit at the set offset forces that source's status bit to 1 from the next cycle until it is cleared.
- R8: `irq_o[b]` is high exactly when some bit of group `b` is set in both status and enable.
- R9: `first_src_o` for group `b` holds the lowest bit index that is set in both status and enable whenever `irq_o[b]` is high.
- R10: Writes to the status offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Asynchronous interrupt sources, group `b` at bits `b*32+31:b*32` |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | NUM_BANKS | One request line per group |
| first_src_o | output | NUM_BANKS*5 | Lowest pending enabled source index per group |

## Verification
The assertions check four properties on every cycle:
- The reported index always points to a pending enabled bit, and no lower bit is pending.
- A clear write removes the latched bits it names, except a bit that takes a new edge in the same cycle.
- A set write shows in status on the next cycle.
- The enable register changes only when its own offset is written.

Behaviours that depend on the input waveform are shown only by the bench scenarios: synchronizer latency, level polarity, the direction selectivity of rising and falling edges, and a level source that persists through a clear. The bench also covers the address window decode and the reset contents of every group.

// File: rtl/irqc_pkg.sv
// Shared constants for the banked interrupt controller.
// Assumes 32 sources per group and a 32-bit register port.
package irqc_pkg;
    localparam int SRC_W       = 32;
    localparam int IDX_W       = $clog2(SRC_W);
    localparam int BANK_BYTES  = 24;
    // Word index inside a group window (byte offset >> 2).
    localparam logic [2:0] W_STATUS = 3'd0;
    localparam logic [2:0] W_ENABLE = 3'd1;
    localparam logic [2:0] W_SET    = 3'd2;
    localparam logic [2:0] W_CLEAR  = 3'd3;
    localparam logic [2:0] W_POL    = 3'd4;
    localparam logic [2:0] W_MODE   = 3'd5;

    // Reset value of a group's trigger-mode register.
    function automatic logic [SRC_W-1:0] mode_reset(input int bank);
        return (bank == 0) ? 32'h0000_E000 : 32'h0;
    endfunction
endpackage

// File: rtl/irqc_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherency is implied.
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Capture the inputs, then retime once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/irqc_ffs.sv
// Lowest-set-bit finder.
// Assumes the caller qualifies the index with its own nonzero flag.
module irqc_ffs #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/irqc_bank.sv
// One group of 32 sources: synchronizer, trigger detection, latched
// status, enable, polarity and trigger-mode registers, request output
// and lowest-index finder.
// Assumes the top asserts wr_en only for this group's window.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             wr_en,
    input  logic [2:0]       word_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] rdata_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] first_o
);
    logic [SRC_W-1:0] s_now, s_prev;
    logic [SRC_W-1:0] enable, pol, mode, lat;
    logic [SRC_W-1:0] active, edge_ev, status, pend;
    logic [SRC_W-1:0] set_m, clr_m;
    logic             wr_set, wr_clr, wr_enable;

    irqc_sync #(.W(SRC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (s_now)
    );

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev <= '0;
        else        s_prev <= s_now;
    end

    assign wr_set    = wr_en && (word_i == W_SET);
    assign wr_clr    = wr_en && (word_i == W_CLEAR);
    assign wr_enable = wr_en && (word_i == W_ENABLE);
    assign set_m     = wr_set ? wdata_i : '0;
    assign clr_m     = wr_clr ? wdata_i : '0;

    // Apply polarity, then pick the matching transition direction.
    always_comb begin
        active  = ~(s_now ^ pol);
        edge_ev = (pol & s_now & ~s_prev) | (~pol & ~s_now & s_prev);
    end

    // Configuration registers written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            pol    <= '1;
            mode   <= mode_reset(BANK_IDX);
        end else if (wr_en) begin
            if (word_i == W_ENABLE) enable <= wdata_i;
            if (word_i == W_POL)    pol    <= wdata_i;
            if (word_i == W_MODE)   mode   <= wdata_i;
        end
    end

    // Latched requests: software sets, edge events, acknowledged by clear.
    always_ff @(posedge clk) begin
        if (!rst_n) lat <= '0;
        else        lat <= (lat & ~clr_m) | set_m | (mode & edge_ev);
    end

    assign status = lat | (~mode & active);
    assign pend   = status & enable;
    assign irq_o  = |pend;

    irqc_ffs #(.W(SRC_W)) u_ffs (
        .vec_i (pend),
        .idx_o (first_o)
    );

    // Register read selection; set and clear read as zero.
    always_comb begin
        unique case (word_i)
            W_STATUS: rdata_o = status;
            W_ENABLE: rdata_o = enable;
            W_POL:    rdata_o = pol;
            W_MODE:   rdata_o = mode;
            default:  rdata_o = '0;
        endcase
    end

    // R9: reported index names a pending enabled source.
    a_r9_first_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend[first_o]);
    // R9: no lower-numbered source is pending.
    a_r9_first_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend & ((32'd1 << first_o) - 32'd1)) == '0));
    // R6: cleared bits drop unless a fresh edge arrived the same cycle.
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((lat & $past(wdata_i & ~(mode & edge_ev))) == '0));
    // R7: set bits appear in status on the next cycle.
    a_r7_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((status & $past(wdata_i)) == $past(wdata_i)));
    // R2: enable changes only through its own offset.
    a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enable));
endmodule

// File: rtl/banked_irq_ctrl.sv
// Banked interrupt controller top: decodes the 24-byte group windows,
// instantiates one group per bank and multiplexes read data.
// Assumes a single-cycle port; read data is combinational from the address.
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 8,
    localparam int SRC_TOTAL = NUM_BANKS * SRC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SRC_TOTAL-1:0]       src_i,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_BANKS-1:0]       irq_o,
    output logic [NUM_BANKS*IDX_W-1:0] first_src_o
);
    logic [NUM_BANKS-1:0] sel;
    logic [2:0]           word_sel;
    logic [31:0]          bank_rd [NUM_BANKS];

    // Find which group window the address falls in and the word inside it.
    always_comb begin
        sel      = '0;
        word_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bus_addr) >= b * BANK_BYTES &&
                int'(bus_addr) < (b + 1) * BANK_BYTES) begin
                sel[b]   = 1'b1;
                word_sel = 3'((int'(bus_addr) - b * BANK_BYTES) >> 2);
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.BANK_IDX(b)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*SRC_W +: SRC_W]),
            .wr_en   (bus_we && sel[b]),
            .word_i  (word_sel),
            .wdata_i (bus_wdata),
            .rdata_o (bank_rd[b]),
            .irq_o   (irq_o[b]),
            .first_o (first_src_o[b*IDX_W +: IDX_W])
        );
    end

    // Return the selected group's register, zero outside the map.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel[b]) bus_rdata = bank_rd[b];
        end
    end

    // R2: at most one group window decodes any address.
    a_r2_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: tb/banked_irq_ctrl_bench.sv
`timescale 1ns/1ps
module banked_irq_ctrl_bench;
    localparam int NB = 5;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NB-1:0] irq;
    logic [NB*5-1:0] first;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_banked_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .first_src_o(first)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ra(input int bank, input int off);
        return AW'(bank * 24 + off);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents, R2 zero reads of set/clear and unmapped space
        for (int b = 0; b < NB; b++) begin
            rd(ra(b, 0), v);  chk("R1 status", v, 32'h0);
            rd(ra(b, 4), v);  chk("R1 enable", v, 32'h0);
            rd(ra(b, 16), v); chk("R1 polarity", v, 32'hFFFF_FFFF);
            rd(ra(b, 20), v); chk("R1 mode", v, (b == 0) ? 32'h0000_E000 : 32'h0);
            rd(ra(b, 8), v);  chk("R2 set reads 0", v, 32'h0);
            rd(ra(b, 12), v); chk("R2 clear reads 0", v, 32'h0);
        end
        rd(AW'(NB * 24), v); chk("R2 unmapped", v, 32'h0);
        rd(AW'(255), v);     chk("R2 unmapped top", v, 32'h0);

        // R2 window decode: write distinct enables per group, read back
        for (int b = 0; b < NB; b++) wr(ra(b, 4), 32'h1111_0000 * (b + 1) + b);
        for (int b = 0; b < NB; b++) begin
            rd(ra(b, 4), v); chk("R2 enable window", v, 32'h1111_0000 * (b + 1) + b);
        end

        // R3/R8/R9 level-high sweep over every source
        wr(ra(0, 20), 32'h0);
        for (int b = 0; b < NB; b++) wr(ra(b, 4), 32'hFFFF_FFFF);
        for (int g = 0; g < NB * 32; g++) begin
            src = '0; src[g] = 1'b1;
            settle();
            rd(ra(g / 32, 0), v);
            chk("R3 level-high status", v, 32'd1 << (g % 32));
            chk("R8 one request line", 32'(irq), 32'd1 << (g / 32));
            chk("R9 index single", 32'(first[(g/32)*5 +: 5]), 32'(g % 32));
            src = '0;
            settle();
        end
        chk("R8 idle", 32'(irq), 32'h0);

        // R3 level-low on group 0
        wr(ra(0, 16), 32'h0);
        settle();
        rd(ra(0, 0), v); chk("R3 level-low idle", v, 32'hFFFF_FFFF);
        src[31:0] = 32'hFFFF_0000;
        settle();
        rd(ra(0, 0), v); chk("R3 level-low partial", v, 32'h0000_FFFF);
        src[31:0] = 32'h0;
        wr(ra(0, 16), 32'hFFFF_FFFF);
        settle();

        // R9 lowest index with several pending sources in group 1
        for (int k = 0; k < 32; k++) begin
            src[63:32] = ~((32'd1 << k) - 32'd1);
            settle();
            chk("R9 lowest of many", 32'(first[9:5]), 32'(k));
        end
        wr(ra(1, 4), 32'h8000_0000);
        src[63:32] = 32'hFFFF_FFFF;
        settle();
        chk("R9 enable masks lower", 32'(first[9:5]), 32'd31);
        wr(ra(1, 4), 32'h0);
        chk("R8 disabled group quiet", 32'(irq[1]), 32'h0);
        src[63:32] = 32'h0;
        settle();

        // R4 rising edge latch and R6 clear on group 2
        wr(ra(2, 20), 32'hFFFF_FFFF);
        for (int k = 0; k < 32; k += 5) begin
            src[64 + k] = 1'b1;
            settle();
            src[64 + k] = 1'b0;
            settle();
            rd(ra(2, 0), v); chk("R4 rising latched", v, 32'd1 << k);
            wr(ra(2, 12), ~(32'd1 << k));
            rd(ra(2, 0), v); chk("R6 clear zero bits no effect", v, 32'd1 << k);
            wr(ra(2, 12), 32'd1 << k);
            rd(ra(2, 0), v); chk("R6 clear drops latch", v, 32'h0);
        end

        // R5 falling edge on group 2
        wr(ra(2, 16), 32'h0);
        src[64 + 7] = 1'b1;
        settle();
        rd(ra(2, 0), v); chk("R5 rise ignored", v, 32'h0);
        src[64 + 7] = 1'b0;
        settle();
        rd(ra(2, 0), v); chk("R5 fall latched", v, 32'h80);
        wr(ra(2, 12), 32'hFFFF_FFFF);
        rd(ra(2, 0), v); chk("R6 clear falling", v, 32'h0);

        // R6 level source persists through a clear (group 3)
        src[96 + 4] = 1'b1;
        settle();
        wr(ra(3, 12), 32'h10);
        rd(ra(3, 0), v); chk("R6 level persists", v, 32'h10);
        src[96 + 4] = 1'b0;
        settle();
        rd(ra(3, 0), v); chk("R6 level released", v, 32'h0);

        // R7 software set, R8 request, then clear (group 4)
        wr(ra(4, 4), 32'hFFFF_FFFF);
        wr(ra(4, 8), 32'h0000_0A00);
        rd(ra(4, 0), v); chk("R7 set forces status", v, 32'h0000_0A00);
        chk("R8 set raises request", 32'(irq[4]), 32'h1);
        chk("R9 set index", 32'(first[24:20]), 32'd9);
        wr(ra(4, 12), 32'h0000_0A00);
        rd(ra(4, 0), v); chk("R7 set cleared", v, 32'h0);
        chk("R8 request drops", 32'(irq[4]), 32'h0);

        // R10 status writes ignored
        wr(ra(4, 0), 32'hFFFF_FFFF);
        rd(ra(4, 0), v);  chk("R10 status write ignored", v, 32'h0);
        rd(ra(4, 4), v);  chk("R10 enable untouched", v, 32'hFFFF_FFFF);
        rd(ra(4, 16), v); chk("R10 polarity untouched", v, 32'hFFFF_FFFF);
        rd(ra(4, 20), v); chk("R10 mode untouched", v, 32'h0);
        chk("R10 no request", 32'(irq[4]), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule